// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a down-counting supervision timer. Software sets a reload value and then starts the count. If software does not service the timer before the count runs out, the first expiry raises an interrupt request and the count restarts from the reload value. If that request is still unserviced when the count runs out again, the block drives a reset request that lasts a fixed number of clocks. Software services the timer by writing the kick register. That write clears the pending request and restarts the count.

Configuration goes through a simple synchronous register port, and read data comes back one cycle after the read strobe. A lock register protects the reload value and the control fields against stray writes. Writing the unlock key to it opens them. Writing any other value closes them. Kicking still works while the block is locked, so a locked, correctly serviced system keeps running.

Top module: `wd_twostage`

## Requirements
- R1: With the run bit (control bit 0) set, the counter counts down one step per clock. One cycle after it reaches zero, the block raises the pending interrupt and reloads the counter. A reload value L therefore gives a first expiry L+1 cycles after the count is started from L.
- R2: An expiry that occurs while the interrupt is already pending, with reset enabled, starts the reset output one clock after that expiry. Measured from the start of the count, the reset output rises 2L+3 cycles later.
- R3: Control bit 1 gates the interrupt output and control bit 2 gates reset generation. With bit 1 clear, irq_o stays low but the pending flag still sets. With bit 2 clear, rst_o never rises.
- R4: A write to address 2 (kick) clears the pending flag and reloads the counter, whether the block is locked or not. An accepted write to the reload register (address 0) also reloads the counter.
- R5: The reset output stays high for exactly RST_HOLD clocks. A further second-stage expiry while it is high is ignored.
- R6: While the block is locked, writes to the reload register (address 0) and the control register (address 1) change nothing.
- R7: A write of UNLOCK_KEY to address 3 unlocks the block, and a write of any other value locks it. A read of address 3 returns the lock state in bit 0 and the pending flag in bit 1.
- R8: A read returns its data one cycle after rd_en. Address 0 returns the reload value, address 1 returns the control bits, and address 2 returns the live count. After reset the reload value is LOAD_RST, control is 0, the block is unlocked and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | First-stage interrupt request |
| rst_o | output | 1 | Second-stage reset request |

## Verification
The bench builds the block with a 6-bit counter, RST_HOLD of 5 and a reset-time reload value of 10. The narrow counter makes it practical to sweep every reload value from 0 to 63, checking the exact first-expiry cycle, the exact reset-rise cycle and the reset width for each one. The short hold lets a reload of 0 re-trigger the second stage on every cycle, which exercises the rule that expiries are ignored while the reset output is high. The lock, key and kick-while-locked sequences are checked by reading the registers back.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    WD_LOAD = 2'd0,
    WD_CTRL = 2'd1,
    WD_KICK = 2'd2,
    WD_LOCK = 2'd3
  } wd_addr_e;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
    logic run;
  } wd_ctrl_t;

  localparam int CTRL_W = $bits(wd_ctrl_t);
endpackage

// File: rtl/wd_cfg_regs.sv
module wd_cfg_regs
  import wd_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC0DE_5A5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  load_q,
  output wd_ctrl_t          ctrl_q,
  output logic              locked_q,
  output logic              load_wr,
  output logic              kick
);
  logic open_wr;

  assign open_wr = wr_en && !locked_q;
  assign load_wr = open_wr && (addr == WD_LOAD);
  assign kick    = wr_en && (addr == WD_KICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= LOAD_RST;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (load_wr)
        load_q <= wdata[CNT_W-1:0];
      if (open_wr && addr == WD_CTRL)
        ctrl_q <= wd_ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_en && addr == WD_LOCK)
        locked_q <= (wdata != UNLOCK_KEY);
    end
  end
endmodule

// File: rtl/wd_stage_cnt.sv
module wd_stage_cnt #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] load_q,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_new,
  input  logic             kick,
  output logic [CNT_W-1:0] count,
  output logic             pend,
  output logic             bite
);
  logic expire;

  assign expire = run && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= LOAD_RST;
      pend  <= 1'b0;
      bite  <= 1'b0;
    end else begin
      bite <= 1'b0;
      if (kick) begin
        pend  <= 1'b0;
        count <= load_q;
      end else if (load_wr) begin
        count <= load_new;
      end else if (expire) begin
        count <= load_q;
        if (!pend)
          pend <= 1'b1;
        else if (rst_en)
          bite <= 1'b1;
      end else if (run) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wd_rst_hold.sv
module wd_rst_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bite,
  output logic rst_o
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_o <= 1'b0;
      left  <= '0;
    end else if (!rst_o) begin
      if (bite) begin
        rst_o <= 1'b1;
        left  <= LAST;
      end
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      rst_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wd_twostage.sv
module wd_twostage
  import wd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int RST_HOLD = 16,
  parameter logic [CNT_W-1:0]  LOAD_RST   = '1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC0DE_5A5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              rst_o
);
  logic [CNT_W-1:0] load_q;
  wd_ctrl_t         ctrl_q;
  logic             locked;
  logic             load_wr;
  logic             kick;
  logic [CNT_W-1:0] count;
  logic             irq_pend;
  logic             bite;

  wd_cfg_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .LOAD_RST(LOAD_RST), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .load_q(load_q), .ctrl_q(ctrl_q), .locked_q(locked),
    .load_wr(load_wr), .kick(kick)
  );

  wd_stage_cnt #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .rst_en(ctrl_q.rst_en),
    .load_q(load_q), .load_wr(load_wr), .load_new(wdata[CNT_W-1:0]),
    .kick(kick), .count(count), .pend(irq_pend), .bite(bite)
  );

  wd_rst_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk(clk), .rst(rst), .bite(bite), .rst_o(rst_o)
  );

  assign irq_o = irq_pend && ctrl_q.irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      case (addr)
        WD_LOAD: rdata[CNT_W-1:0]  <= load_q;
        WD_CTRL: rdata[CTRL_W-1:0] <= ctrl_q;
        WD_KICK: rdata[CNT_W-1:0]  <= count;
        default: rdata[1:0]        <= {irq_pend, locked};
      endcase
    end
  end
endmodule

// File: rtl/wd_twostage_chk.sv
module wd_twostage_chk #(
  parameter int CNT_W = 16,
  parameter int HOLD  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             rst_o,
  input logic             irq_pend,
  input logic             locked,
  input logic             run,
  input logic [CNT_W-1:0] load_q,
  input logic [2:0]       ctrl_bits
);
  localparam int LW = $clog2(HOLD + 2) + 1;
  logic [LW-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)        hi_len <= '0;
    else if (rst_o) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  AST_FIRST_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend) |-> $past(run)); // R1
  AST_BITE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> $past(irq_pend)); // R2
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2) |=> !irq_pend); // R4
  AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> (hi_len == LW'(HOLD))); // R5
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(load_q) && $stable(ctrl_bits))); // R6
endmodule

bind wd_twostage wd_twostage_chk #(.CNT_W(CNT_W), .HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .rst_o(rst_o),
  .irq_pend(irq_pend), .locked(locked), .run(ctrl_q.run),
  .load_q(load_q), .ctrl_bits(ctrl_q)
);

// File: tb/wd_twostage_tb.sv
module wd_twostage_tb;
  localparam int CNT_W = 6;
  localparam int HOLD  = 5;
  localparam int LRST  = 10;
  localparam logic [31:0] KEY = 32'hC0DE_5A5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_o, rst_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wd_twostage #(.CNT_W(CNT_W), .DATA_W(32), .RST_HOLD(HOLD),
    .LOAD_RST(6'(LRST)), .UNLOCK_KEY(KEY)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .rst_o(rst_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Index n = state after the n-th edge following the last write edge.
  task automatic watch(input int len, output int t_irq, output int t_rst,
                       output int w_rst);
    bit high_run = 0;
    t_irq = -1; t_rst = -1; w_rst = 0;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      if (irq_o && t_irq < 0) t_irq = n;
      if (rst_o && t_rst < 0) begin t_rst = n; high_run = 1; end
      if (high_run) begin
        if (rst_o) w_rst++;
        else high_run = 0;
      end
    end
  endtask

  task automatic prep(input int l);
    wr(2'd1, 32'd0);
    idle(HOLD + 2);
    wr(2'd0, 32'(l));
    wr(2'd2, 32'd0);
  endtask

  initial begin
    int v, ti, tr, wrs;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!irq_o && !rst_o, "R8 outputs low after reset", {irq_o, rst_o}, 0);
    rd(2'd0, v); chk(v == LRST, "R8 reset load", v, LRST);
    rd(2'd1, v); chk(v == 0, "R8 reset ctrl", v, 0);
    rd(2'd3, v); chk(v == 0, "R7 reset unlocked", v, 0);
    rd(2'd2, v); chk(v == LRST, "R8 reset count", v, LRST);

    // R1 R2 R5 sweep over every reload value
    for (int l = 0; l < 64; l++) begin
      prep(l);
      wr(2'd1, 32'd7);
      watch(2*l + 3 + HOLD + 2, ti, tr, wrs);
      chk(ti == l + 1, "R1 first expiry", ti, l + 1);
      chk(tr == 2*l + 3, "R2 reset rise", tr, 2*l + 3);
      chk(wrs == HOLD, "R5 reset width", wrs, HOLD);
    end

    // R3 irq masked, reset still generated
    for (int l = 2; l < 12; l += 3) begin
      prep(l);
      wr(2'd1, 32'd5);
      watch(2*l + 4, ti, tr, wrs);
      chk(ti == -1, "R3 irq masked", ti, -1);
      chk(tr == 2*l + 3, "R3 reset without irq_en", tr, 2*l + 3);
      rd(2'd3, v); chk(v[1] == 1'b1, "R3 pend set while masked", v, 2);
    end
    // R3 reset disabled
    for (int l = 1; l < 10; l += 4) begin
      prep(l);
      wr(2'd1, 32'd3);
      watch(3*l + 8, ti, tr, wrs);
      chk(ti == l + 1, "R3 irq with reset off", ti, l + 1);
      chk(tr == -1, "R3 no reset when disabled", tr, -1);
    end

    // R4 kick clears and reloads
    prep(8);
    wr(2'd1, 32'd7);
    watch(10, ti, tr, wrs);
    chk(ti == 9, "R4 setup irq", ti, 9);
    wr(2'd2, 32'd0);
    chk(!irq_o, "R4 kick clears irq", irq_o, 0);
    watch(25, ti, tr, wrs);
    chk(ti == 9, "R4 irq after kick", ti, 9);
    chk(tr == 19, "R4 reset after kick", tr, 19);

    // R4 R8 load write reloads counter, count readable
    prep(20);
    wr(2'd0, 32'd13);
    rd(2'd2, v); chk(v == 13, "R4 load write reloads count", v, 13);
    rd(2'd0, v); chk(v == 13, "R8 read load", v, 13);

    // R6 R7 lock behaviour
    wr(2'd1, 32'd3);
    watch(16, ti, tr, wrs);
    chk(irq_o, "R1 irq before lock", irq_o, 1);
    wr(2'd3, 32'h55);
    rd(2'd3, v); chk(v == 3, "R7 locked status", v, 3);
    wr(2'd0, 32'd3);
    rd(2'd0, v); chk(v == 13, "R6 load write ignored", v, 13);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk(v == 3, "R6 ctrl write ignored", v, 3);
    wr(2'd2, 32'd0);
    chk(!irq_o, "R4 kick while locked", irq_o, 0);
    wr(2'd3, 32'h77);
    rd(2'd3, v); chk(v[0] == 1'b1, "R7 other value keeps lock", v, 1);
    wr(2'd3, KEY);
    rd(2'd3, v); chk(v[0] == 1'b0, "R7 key unlocks", v, 0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd21);
    rd(2'd0, v); chk(v == 21, "R7 write after unlock", v, 21);
    rd(2'd1, v); chk(v == 0, "R7 ctrl after unlock", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule